// File: doc/BRIEF.md
# Torus Escape-Channel Virtual-Channel Selector

This unit decides, for one input port of a torus router, where the head flit waiting at that port goes next and on which virtual channel. The network is a k-ary n-cube with wraparound links in both directions along every dimension. For each head flit the unit receives the coordinates of the current node, the coordinates of the destination, the class the flit arrived with (adaptive, or escape at a given level), and a bit for every downstream virtual channel telling whether it is currently free. It returns a grant together with the dimension, the direction, the virtual channel, and the class to write into the flit's sideband for the next hop.

Each output port has two kinds of virtual channels. The first `NADAPT` channels form an adaptive pool, and any productive port may use them. The remaining `NDIM+1` channels form an escape set. The escape set is routed deterministically, one dimension at a time with the lowest dimension first. Its level goes up by one on every hop that crosses a wraparound link, so the ring's cyclic channel dependence is split across levels. A packet starts in the adaptive pool. If no adaptive channel is free on any productive port for `BLOCK_LIMIT` consecutive cycles, the packet drops into the escape set. Once a packet is in the escape set it never returns to the adaptive pool.

Switch arbitration, credit counting and flit storage are handled by other blocks.

Top module: `tor_vc_select`

## Requirements
- R1: When the current coordinates equal the destination in every dimension, a valid request is granted in the same cycle with `out_local`=1, `out_dim`=0, `out_neg`=0 and `out_vc`=0, whatever the state of the virtual channels. `out_esc` then reports the current class and `out_level` the incoming escape level (0 for an adaptive packet).
- R2: For each dimension, let delta = (dst - cur) mod K. The route goes in the minus direction (`out_neg`=1) when delta > K/2, and otherwise in the plus direction. A tie therefore goes plus.
- R3: In adaptive mode, the unit scans the unresolved dimensions from lowest to highest and, within each, the adaptive channels from 0 to NADAPT-1. It grants the first one whose free bit is set. The free bit for dimension d, direction bit s and channel v is `vc_free[(2*d+s)*NVC+v]`, where NVC = NADAPT+NDIM+1.
- R4: In escape mode the unit always routes the lowest unresolved dimension.
- R5: In escape mode the channel is NADAPT+L. L is the incoming level, or 0 for a packet that is just entering the escape set. L is increased by one when the hop crosses a wraparound link (plus direction from coordinate K-1, or minus direction from coordinate 0), and it saturates at NDIM.
- R6: An adaptive packet switches to escape mode only after BLOCK_LIMIT consecutive requesting cycles in which no adaptive channel on a productive port was free. If an adaptive channel frees earlier, the packet is granted adaptively.
- R7: A packet that arrives with `in_esc`=1, or that has switched to escape mode, is never given an adaptive channel. It waits for its escape channel even when adaptive channels are free.
- R8: A non-local grant is asserted only when the selected channel's free bit is set. No grant is asserted without a valid request.
- R9: On every non-local grant, `out_esc` is 1 exactly when `out_vc` >= NADAPT, and `out_level` is the level carried to the next hop (0 for adaptive).
- R10: Deasserting `req_valid` or granting clears the blocked count and the escape switch, and so does reset. The next request therefore starts adaptive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A head flit is waiting for a route |
| cur_coord | input | NDIM*CW | Current node; dimension d occupies bits [d*CW +: CW] |
| dst_coord | input | NDIM*CW | Destination node, same packing |
| in_esc | input | 1 | Sideband class of the arriving flit: 1 = escape |
| in_level | input | LW | Sideband escape level of the arriving flit |
| vc_free | input | 2*NDIM*NVC | Free bit per downstream virtual channel, indexed as in R3 |
| grant | output | 1 | The selected route and channel may be taken this cycle |
| out_local | output | 1 | Packet has arrived; eject locally |
| out_dim | output | DW | Dimension of the chosen output |
| out_neg | output | 1 | Direction: 1 = minus, 0 = plus |
| out_vc | output | VW | Virtual channel index on the chosen output |
| out_esc | output | 1 | Sideband class sent onward |
| out_level | output | LW | Sideband escape level sent onward |

## Verification
The assertions assume that coordinates, destination and sideband class are held steady for as long as `req_valid` stays high without a grant, and that `in_level` never exceeds NDIM. The blocked-window and level-monotonicity checks depend on both conditions. The stimulus changes the route inputs only on cycles where `req_valid` is low or a grant is given, and it only drives levels from 0 to NDIM. The sweeps cover every pair of coordinates on a 4-ary 2-cube, in both adaptive and escape classes and at every escape level. Directed sequences cover the blocked window, the wait for an escape channel, and the early adaptive release.

// File: rtl/tor_route_pkg.sv
// Shared definitions for the torus virtual-channel selector.
// Assumes: included first in compile order.
package tor_route_pkg;
    // Routing class of the packet at this hop.
    typedef enum logic {
        MODE_ADAPT = 1'b0,
        MODE_ESC   = 1'b1
    } route_mode_e;
endpackage

// File: rtl/tor_dim_step.sv
// Per-dimension step decision: resolved flag, minimal direction and wrap flag.
// Assumes: cur and dst are in 0..K-1; ties of K/2 go in the plus direction.
module tor_dim_step #(
    parameter int K  = 4,
    parameter int CW = 2
) (
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] dst,
    output logic          done,
    output logic          neg,
    output logic          wrap
);
    localparam logic [CW:0] KW   = (CW+1)'(K);
    localparam logic [CW:0] HALF = (CW+1)'(K / 2);

    logic [CW:0] delta;

    // Distance in the plus direction, modulo K.
    always_comb begin
        if (dst >= cur) delta = {1'b0, dst} - {1'b0, cur};
        else            delta = {1'b0, dst} + KW - {1'b0, cur};
    end

    // Direction choice and detection of a hop across the wraparound link.
    always_comb begin
        done = (cur == dst);
        neg  = !done && (delta > HALF);
        wrap = !done && (neg ? (cur == '0) : (cur == CW'(K - 1)));
    end
endmodule

// File: rtl/tor_block_timer.sv
// Counts consecutive blocked cycles of an adaptive request and raises a
// sticky escape flag once the limit is reached.
// Assumes: clear is pulsed when the request is granted; LIMIT >= 1.
module tor_block_timer #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic blocked,
    input  logic clear,
    output logic esc_now
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt;

    // Blocked-cycle counter with a sticky switch into the escape set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            esc_now <= 1'b0;
        end else if (!active || clear) begin
            cnt     <= '0;
            esc_now <= 1'b0;
        end else if (!esc_now && blocked) begin
            cnt <= cnt + 1'b1;
            if (cnt == TW'(LIMIT - 1)) esc_now <= 1'b1;
        end
    end
endmodule

// File: rtl/tor_adapt_pick.sv
// Fixed-priority search of the adaptive pool over productive output ports.
// Assumes: want marks unresolved dimensions; neg gives each one's direction.
module tor_adapt_pick #(
    parameter int NDIM   = 2,
    parameter int NADAPT = 2,
    parameter int NVC    = 5,
    parameter int DW     = 1,
    parameter int VW     = 3
) (
    input  logic [NDIM-1:0]       want,
    input  logic [NDIM-1:0]       neg,
    input  logic [2*NDIM*NVC-1:0] vc_free,
    output logic                  found,
    output logic [DW-1:0]         dim,
    output logic [VW-1:0]         vc
);
    // Lowest dimension first, then lowest adaptive channel.
    always_comb begin
        found = 1'b0;
        dim   = '0;
        vc    = '0;
        for (int d = 0; d < NDIM; d++) begin
            for (int v = 0; v < NADAPT; v++) begin
                if (!found && want[d] && vc_free[(2 * d + int'(neg[d])) * NVC + v]) begin
                    found = 1'b1;
                    dim   = DW'(d);
                    vc    = VW'(v);
                end
            end
        end
    end
endmodule

// File: rtl/tor_vc_select.sv
// Route and virtual-channel selector for one input port of a bidirectional
// k-ary n-cube torus. Adaptive pool first; after a blocked window the packet
// moves to dimension-ordered escape channels whose level rises at each wrap.
// Assumes: route inputs stay stable while a request waits; in_level <= NDIM.
module tor_vc_select
    import tor_route_pkg::*;
#(
    parameter int NDIM        = 2,
    parameter int K           = 4,
    parameter int NADAPT      = 2,
    parameter int BLOCK_LIMIT = 3,
    parameter int CW          = $clog2(K),
    parameter int NVC         = NADAPT + NDIM + 1,
    parameter int LW          = $clog2(NDIM + 1),
    parameter int DW          = (NDIM > 1) ? $clog2(NDIM) : 1,
    parameter int VW          = $clog2(NVC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [NDIM*CW-1:0]    cur_coord,
    input  logic [NDIM*CW-1:0]    dst_coord,
    input  logic                  in_esc,
    input  logic [LW-1:0]         in_level,
    input  logic [2*NDIM*NVC-1:0] vc_free,
    output logic                  grant,
    output logic                  out_local,
    output logic [DW-1:0]         out_dim,
    output logic                  out_neg,
    output logic [VW-1:0]         out_vc,
    output logic                  out_esc,
    output logic [LW-1:0]         out_level
);
    localparam logic [LW-1:0] LMAX = LW'(NDIM);

    logic [NDIM-1:0] dim_done, dim_neg, dim_wrap;
    logic            a_found;
    logic [DW-1:0]   a_dim;
    logic [VW-1:0]   a_vc;
    logic            sticky;
    route_mode_e     mode;
    logic            all_done;
    logic [DW-1:0]   e_dim;
    logic            e_neg, e_wrap, e_free;
    logic [LW-1:0]   lvl_base, lvl_next;
    logic [VW-1:0]   e_vc;

    // One step decision per dimension.
    for (genvar g = 0; g < NDIM; g++) begin : g_dim
        tor_dim_step #(.K(K), .CW(CW)) u_step (
            .cur  (cur_coord[g*CW +: CW]),
            .dst  (dst_coord[g*CW +: CW]),
            .done (dim_done[g]),
            .neg  (dim_neg[g]),
            .wrap (dim_wrap[g])
        );
    end

    tor_adapt_pick #(
        .NDIM(NDIM), .NADAPT(NADAPT), .NVC(NVC), .DW(DW), .VW(VW)
    ) u_pick (
        .want    (~dim_done),
        .neg     (dim_neg),
        .vc_free (vc_free),
        .found   (a_found),
        .dim     (a_dim),
        .vc      (a_vc)
    );

    tor_block_timer #(.LIMIT(BLOCK_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (req_valid && !in_esc),
        .blocked (!a_found && !all_done),
        .clear   (grant),
        .esc_now (sticky)
    );

    // Class in effect at this hop: escape once entered, never back.
    always_comb mode = (in_esc || sticky) ? MODE_ESC : MODE_ADAPT;

    // Lowest unresolved dimension for dimension-ordered escape routing.
    always_comb begin
        all_done = &dim_done;
        e_dim    = '0;
        e_neg    = 1'b0;
        e_wrap   = 1'b0;
        for (int d = NDIM - 1; d >= 0; d--) begin
            if (!dim_done[d]) begin
                e_dim  = DW'(d);
                e_neg  = dim_neg[d];
                e_wrap = dim_wrap[d];
            end
        end
    end

    // Escape level: carried in, raised on a wrap hop, saturated at NDIM.
    always_comb begin
        if (in_esc) lvl_base = (in_level > LMAX) ? LMAX : in_level;
        else        lvl_base = '0;
        lvl_next = (e_wrap && lvl_base != LMAX) ? lvl_base + 1'b1 : lvl_base;
        e_vc     = VW'(NADAPT) + VW'(lvl_next);
        e_free   = vc_free[(2 * int'(e_dim) + int'(e_neg)) * NVC + int'(e_vc)];
    end

    // Final selection and sideband for the next hop.
    always_comb begin
        out_local = all_done;
        out_esc   = (mode == MODE_ESC);
        if (all_done) begin
            grant     = req_valid;
            out_dim   = '0;
            out_neg   = 1'b0;
            out_vc    = '0;
            out_level = lvl_base;
        end else if (mode == MODE_ESC) begin
            grant     = req_valid && e_free;
            out_dim   = e_dim;
            out_neg   = e_neg;
            out_vc    = e_vc;
            out_level = lvl_next;
        end else begin
            grant     = req_valid && a_found;
            out_dim   = a_dim;
            out_neg   = dim_neg[a_dim];
            out_vc    = a_vc;
            out_level = '0;
        end
    end
endmodule

// File: rtl/tor_vc_select_chk.sv
// Checker for tor_vc_select, bound to every instance of it.
// Assumes: route inputs are stable while a request waits; in_level <= NDIM.
module tor_vc_select_chk #(
    parameter int NDIM        = 2,
    parameter int NADAPT      = 2,
    parameter int BLOCK_LIMIT = 3,
    parameter int CW          = 2,
    parameter int NVC         = 5,
    parameter int LW          = 2,
    parameter int DW          = 1,
    parameter int VW          = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [NDIM*CW-1:0]    cur_coord,
    input logic [NDIM*CW-1:0]    dst_coord,
    input logic                  in_esc,
    input logic [LW-1:0]         in_level,
    input logic [2*NDIM*NVC-1:0] vc_free,
    input logic                  grant,
    input logic                  out_local,
    input logic [DW-1:0]         out_dim,
    input logic                  out_neg,
    input logic [VW-1:0]         out_vc,
    input logic                  out_esc,
    input logic [LW-1:0]         out_level
);
    localparam int TW = $clog2(BLOCK_LIMIT + 2);

    logic [TW-1:0] wait_cnt;

    // Consecutive waiting cycles of an adaptive request, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid || grant || in_esc) wait_cnt <= '0;
        else if (wait_cnt != TW'(BLOCK_LIMIT + 1))    wait_cnt <= wait_cnt + 1'b1;
    end

    AST_LOCAL_ONLY_AT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        grant && out_local |-> cur_coord == dst_coord);                          // R1

    AST_ESC_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !out_local && !in_esc && out_esc |-> wait_cnt >= TW'(BLOCK_LIMIT)); // R6

    AST_ESC_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        grant && in_esc |-> out_esc);                                             // R7

    AST_FREE_VC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !out_local |-> vc_free[(2 * int'(out_dim) + int'(out_neg)) * NVC + int'(out_vc)]); // R8

    AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !grant);                                                   // R8

    AST_CLASS_MATCHES_VC: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !out_local |-> out_esc == (out_vc >= VW'(NADAPT)));              // R9

    AST_LEVEL_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        grant && in_esc |-> out_level >= in_level);                               // R5

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_level <= LW'(NDIM));                                                  // R5
endmodule

bind tor_vc_select tor_vc_select_chk #(
    .NDIM(NDIM), .NADAPT(NADAPT), .BLOCK_LIMIT(BLOCK_LIMIT), .CW(CW),
    .NVC(NVC), .LW(LW), .DW(DW), .VW(VW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_coord(cur_coord),
    .dst_coord(dst_coord), .in_esc(in_esc), .in_level(in_level),
    .vc_free(vc_free), .grant(grant), .out_local(out_local), .out_dim(out_dim),
    .out_neg(out_neg), .out_vc(out_vc), .out_esc(out_esc), .out_level(out_level)
);

// File: tb/sim_tor_vc_select.sv
// Bench: sweeps every node pair of a 4-ary 2-cube in both classes, then
// runs directed sequences for the blocked window and the escape wait.
module sim_tor_vc_select;
    localparam int NDIM = 2, K = 4, NADAPT = 2, LIMIT = 3;
    localparam int NVC = NADAPT + NDIM + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  cur_coord = '0, dst_coord = '0;
    logic        in_esc = 1'b0;
    logic [1:0]  in_level = '0;
    logic [19:0] vc_free = '0;
    logic        grant, out_local, out_neg, out_esc;
    logic [0:0]  out_dim;
    logic [2:0]  out_vc;
    logic [1:0]  out_level;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tor_vc_select #(.NDIM(NDIM), .K(K), .NADAPT(NADAPT), .BLOCK_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_coord(cur_coord),
        .dst_coord(dst_coord), .in_esc(in_esc), .in_level(in_level),
        .vc_free(vc_free), .grant(grant), .out_local(out_local), .out_dim(out_dim),
        .out_neg(out_neg), .out_vc(out_vc), .out_esc(out_esc), .out_level(out_level)
    );

    // Packed view of all outputs: {grant,local,dim,neg,vc[2:0],esc,level[1:0]}.
    function automatic logic [9:0] pack(input bit g, input bit l, input int d,
                                        input bit n, input int v, input bit e, input int lv);
        return {g, l, d[0], n, v[2:0], e, lv[1:0]};
    endfunction

    // Expected outputs with every channel free and no blocked history.
    function automatic logic [9:0] expect_free(input int cur, input int dst,
                                               input bit esc, input int lvl);
        for (int d = 0; d < NDIM; d++) begin
            int c = (cur >> (2 * d)) & 3;
            int t = (dst >> (2 * d)) & 3;
            if (c != t) begin
                int  delta = (t - c + K) % K;
                bit  n     = delta > K / 2;
                if (esc) begin
                    bit w = n ? (c == 0) : (c == K - 1);
                    int l = lvl + (w ? 1 : 0);
                    if (l > NDIM) l = NDIM;
                    return pack(1, 0, d, n, NADAPT + l, 1, l);
                end
                return pack(1, 0, d, n, 0, 0, 0);
            end
        end
        return pack(1, 1, 0, 0, 0, esc, esc ? lvl : 0);
    endfunction

    function automatic logic [9:0] actual();
        return {grant, out_local, out_dim, out_neg, out_vc, out_esc, out_level};
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        #1 check_bit("R10 reset grant low", grant, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3: adaptive sweep over all node pairs, every channel free.
        vc_free = '1;
        req_valid = 1'b1;
        for (int c = 0; c < 16; c++) begin
            for (int t = 0; t < 16; t++) begin
                cur_coord = 4'(c);
                dst_coord = 4'(t);
                #1 check("R2/R3 adaptive sweep", actual(), expect_free(c, t, 0, 0));
                @(negedge clk);
            end
        end

        // R4 R5 R9: escape sweep at every incoming level.
        in_esc = 1'b1;
        for (int l = 0; l <= NDIM; l++) begin
            for (int c = 0; c < 16; c++) begin
                for (int t = 0; t < 16; t++) begin
                    cur_coord = 4'(c);
                    dst_coord = 4'(t);
                    in_level  = 2'(l);
                    #1 check("R4/R5 escape sweep", actual(), expect_free(c, t, 1, l));
                    @(negedge clk);
                end
            end
        end

        // R1: arrival is granted even with no channel free.
        in_esc = 1'b0; in_level = '0; vc_free = '0;
        cur_coord = 4'h9; dst_coord = 4'h9;
        #1 check("R1 local with none free", actual(), pack(1, 1, 0, 0, 0, 0, 0));
        @(negedge clk);

        // R3: only Y-plus adaptive VC1 free (bit 11) with both dimensions open.
        cur_coord = 4'h0; dst_coord = 4'h5;
        vc_free = 20'(1) << 11;
        #1 check("R3 pick later dim/vc", actual(), pack(1, 0, 1, 0, 1, 0, 0));
        @(negedge clk);

        // R3: X-minus adaptive VC0 free (bit 5); destination x=3 from x=0.
        dst_coord = 4'h3;
        vc_free = 20'(1) << 5;
        #1 check("R3 minus port adaptive", actual(), pack(1, 0, 0, 1, 0, 0, 0));
        @(negedge clk);

        // R7 R8: escape packet, its escape VC (X-plus VC2, bit 2) busy, rest free.
        in_esc = 1'b1; in_level = '0;
        dst_coord = 4'h1;
        vc_free = ~(20'(1) << 2);
        #1 check_bit("R7 escape waits despite free adaptive", grant, 1'b0);
        check_bit("R7 class stays escape", out_esc, 1'b1);
        @(negedge clk);
        req_valid = 1'b0; in_esc = 1'b0;
        @(negedge clk);

        // R6: blocked window; escape set free, adaptive pool busy.
        vc_free = 20'b11100_11100_11100_11100;
        dst_coord = 4'h5;
        req_valid = 1'b1;
        for (int i = 0; i < LIMIT; i++) begin
            #1 check_bit("R6 no grant inside window", grant, 1'b0);
            @(negedge clk);
        end
        #1 check("R6 escape after window", actual(), pack(1, 0, 0, 0, 2, 1, 0));
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);

        // R7: after switching, adaptive frees but escape busy -> still waits.
        vc_free = 20'b11100_11100_11100_11100;
        req_valid = 1'b1;
        repeat (LIMIT) @(negedge clk);
        vc_free = 20'b00011_00011_00011_00011;
        #1 check_bit("R7 no return to adaptive", grant, 1'b0);
        check_bit("R7 sticky escape class", out_esc, 1'b1);
        @(negedge clk);
        vc_free = 20'b00111_00111_00111_00111;
        #1 check("R8 escape granted once free", actual(), pack(1, 0, 0, 0, 2, 1, 0));
        @(negedge clk);

        // R10: a granted request clears the switch; next request starts adaptive.
        #1 check("R10 fresh request adaptive", actual(), pack(1, 0, 0, 0, 0, 0, 0));
        @(negedge clk);

        // R6: blocked one cycle short of the limit, then an adaptive VC frees.
        req_valid = 1'b0;
        @(negedge clk);
        vc_free = 20'b11100_11100_11100_11100;
        req_valid = 1'b1;
        repeat (LIMIT - 1) @(negedge clk);
        vc_free = 20'b11110_11110_11110_11110;
        #1 check("R6 early adaptive release", actual(), pack(1, 0, 0, 0, 1, 0, 0));
        @(negedge clk);

        // R8: no request means no grant.
        req_valid = 1'b0;
        #1 check_bit("R8 idle no grant", grant, 1'b0);
        @(negedge clk);

        finish_run();
    end
endmodule